// File: doc/BRIEF.md
# Prescaled Interval Timer Trio

Three independent interval timers for a sound co-processor's I/O space, all advanced by one shared base clock enable (nominally 1.024 MHz). Each timer divides the base enable by a fixed prescale factor to make its own tick. The tick advances an internal up-count, and that count is compared against a software-loaded 8-bit period. Each time the count reaches the period it restarts from zero and bumps a small 4-bit output counter, which software polls.

The output counter is the only thing software sees. A read strobe returns its value and clears it, so software learns how many periods have elapsed since its last poll. A write strobe on the counter also clears it. Raising a timer's enable restarts it from a clean state, including the phase of its prescaler. Address decode lives outside this block: each timer has its own enable, period-write, counter-read and counter-write strobes, and one shared period data bus.

Top module: `snd_interval_timers`

## Requirements
- R1: After reset, every output counter reads 0 and every period register holds 0, which acts as a period of 256.
- R2: Timer 2 takes one tick for every 16 cycles with `base_tick` high. Timers 0 and 1 take one tick for every 128 such cycles. Cycles with `base_tick` low do not advance the prescaler.
- R3: With `base_tick` held high and the enable raised at clock edge E, a timer's output count m edges after E equals floor(m / (DIV*P)) mod 16, where DIV is its prescale factor and P is its period.
- R4: The output counter is 4 bits wide and wraps from 15 to 0.
- R5: A period register value of 0 gives a period of 256 ticks.
- R6: `cnt_val` shows each counter's current value (timer i in bits [4i+3:4i]). A read strobe clears that counter at the next clock edge.
- R7: A write strobe on a timer's counter clears that counter at the next clock edge.
- R8: While a timer's enable is low, its output counter holds its value and its prescaler and internal count do not advance.
- R9: The clock edge at which a timer's enable is first seen high clears its internal count and output counter and restarts its prescaler phase.
- R10: If a clear and an increment fall on the same edge, the clear wins and the increment is lost.
- R11: Writing a period equal to the loaded one has no effect. A different value is used at the next comparison, and the internal count is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | Shared base clock enable |
| tmr_en | input | 3 | Per-timer run enable |
| per_wr | input | 3 | Per-timer period write strobe |
| per_data | input | 8 | Period value, shared by all timers |
| cnt_rd | input | 3 | Per-timer counter read strobe (clears the counter) |
| cnt_wr | input | 3 | Per-timer counter write strobe (clears the counter) |
| cnt_val | output | 12 | Output counters, 4 bits per timer |

## Verification
The bench places a read strobe on exactly the edge where an increment is due. A design that let the increment through would show 1 instead of 0, and every later count would be offset by one. It disables a timer in the middle of a prescale phase and then re-enables it. A design that kept the old phase would produce its first count early, well before 16 cycles. It rewrites an unchanged period in the middle of a count, where a design that reset the internal count on every write would report late. It changes the period in the middle of a count, where a design that ignored the change or restarted the count would report at the wrong edge. Period 0 and the 15-to-0 wrap are checked at the exact edges, which exposes a period of 0 treated as 0 and an output counter of the wrong width.

// File: rtl/snd_tmr_pkg.sv
package snd_tmr_pkg;
   localparam int unsigned TMR_COUNT_DEF = 3;
   localparam int unsigned PERIOD_W_DEF  = 8;
   localparam int unsigned OUTCNT_W_DEF  = 4;
   localparam int unsigned SLOW_DIV_DEF  = 128;
   localparam int unsigned FAST_DIV_DEF  = 16;

   function automatic int unsigned ctr_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/snd_tmr_prescale.sv
module snd_tmr_prescale #(
   parameter int unsigned DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic base_tick,
   output logic tick
);
   localparam int unsigned    PH_W = snd_tmr_pkg::ctr_width(DIV);
   localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("snd_tmr_prescale: DIV must be at least 2");
   end

   logic [PH_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                phase_q <= '0;
      else if (start)            phase_q <= '0;
      else if (run && base_tick) phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
   end

   assign tick = run && !start && base_tick && (phase_q == LAST);
endmodule

// File: rtl/snd_tmr_period.sv
module snd_tmr_period #(
   parameter int unsigned PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             per_wr,
   input  logic [PER_W-1:0] per_data,
   output logic             wrap
);
   if (PER_W < 1) begin : g_bad_w
      $error("snd_tmr_period: PER_W must be positive");
   end

   logic [PER_W-1:0] per_q;
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] cnt_nxt;

   // a zero period matches after the count rolls over: 2**PER_W ticks
   assign cnt_nxt = cnt_q + 1'b1;
   assign wrap    = tick && (cnt_nxt == per_q);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (start) cnt_q <= '0;
      else if (tick)  cnt_q <= wrap ? '0 : cnt_nxt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                              per_q <= '0;
      else if (per_wr && (per_data != per_q)) per_q <= per_data;
   end
endmodule

// File: rtl/snd_tmr_outcnt.sv
module snd_tmr_outcnt #(
   parameter int unsigned OUT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             clr,
   input  logic             wrap,
   output logic [OUT_W-1:0] cnt
);
   if (OUT_W < 1) begin : g_bad_w
      $error("snd_tmr_outcnt: OUT_W must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt <= '0;
      else if (start || clr)  cnt <= '0;
      else if (wrap)          cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/snd_interval_timers.sv
module snd_interval_timers #(
   parameter int unsigned              NUM_TMR  = snd_tmr_pkg::TMR_COUNT_DEF,
   parameter int unsigned              PER_W    = snd_tmr_pkg::PERIOD_W_DEF,
   parameter int unsigned              OUT_W    = snd_tmr_pkg::OUTCNT_W_DEF,
   parameter int unsigned              SLOW_DIV = snd_tmr_pkg::SLOW_DIV_DEF,
   parameter int unsigned              FAST_DIV = snd_tmr_pkg::FAST_DIV_DEF,
   parameter logic [NUM_TMR-1:0]       FAST_SEL = 3'b100
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     base_tick,
   input  logic [NUM_TMR-1:0]       tmr_en,
   input  logic [NUM_TMR-1:0]       per_wr,
   input  logic [PER_W-1:0]         per_data,
   input  logic [NUM_TMR-1:0]       cnt_rd,
   input  logic [NUM_TMR-1:0]       cnt_wr,
   output logic [NUM_TMR*OUT_W-1:0] cnt_val
);
   if (NUM_TMR < 1) begin : g_bad_num
      $error("snd_interval_timers: NUM_TMR must be positive");
   end

   logic [NUM_TMR-1:0] en_q;
   logic [NUM_TMR-1:0] start;
   logic [NUM_TMR-1:0] tick;
   logic [NUM_TMR-1:0] wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= tmr_en;
   end

   assign start = tmr_en & ~en_q;

   for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
      if (FAST_SEL[g]) begin : g_fast
         snd_tmr_prescale #(.DIV(FAST_DIV)) u_pre (
            .clk(clk), .rst_n(rst_n), .start(start[g]), .run(tmr_en[g]),
            .base_tick(base_tick), .tick(tick[g]));
      end else begin : g_slow
         snd_tmr_prescale #(.DIV(SLOW_DIV)) u_pre (
            .clk(clk), .rst_n(rst_n), .start(start[g]), .run(tmr_en[g]),
            .base_tick(base_tick), .tick(tick[g]));
      end

      snd_tmr_period #(.PER_W(PER_W)) u_per (
         .clk(clk), .rst_n(rst_n), .start(start[g]), .tick(tick[g]),
         .per_wr(per_wr[g]), .per_data(per_data), .wrap(wrap[g]));

      snd_tmr_outcnt #(.OUT_W(OUT_W)) u_out (
         .clk(clk), .rst_n(rst_n), .start(start[g]),
         .clr(cnt_rd[g] | cnt_wr[g]), .wrap(wrap[g]),
         .cnt(cnt_val[g*OUT_W +: OUT_W]));
   end
endmodule

// File: rtl/snd_interval_timers_chk.sv
module snd_interval_timers_chk #(
   parameter int unsigned NUM_TMR = 3,
   parameter int unsigned OUT_W   = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_TMR-1:0]       tmr_en,
   input logic [NUM_TMR-1:0]       cnt_rd,
   input logic [NUM_TMR-1:0]       cnt_wr,
   input logic [NUM_TMR*OUT_W-1:0] cnt_val
);
   for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
      // R6 R7 R10
      clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_rd[g] || cnt_wr[g]) |=> (cnt_val[g*OUT_W +: OUT_W] == '0));

      // R8
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!tmr_en[g] && !cnt_rd[g] && !cnt_wr[g]) |=> $stable(cnt_val[g*OUT_W +: OUT_W]));

      // R9
      enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(tmr_en[g]) |=> (cnt_val[g*OUT_W +: OUT_W] == '0));

      // R3 R4
      step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_val[g*OUT_W +: OUT_W] != $past(cnt_val[g*OUT_W +: OUT_W])) |->
            ((cnt_val[g*OUT_W +: OUT_W] == '0) ||
             (cnt_val[g*OUT_W +: OUT_W] == $past(cnt_val[g*OUT_W +: OUT_W]) + 1'b1)));
   end
endmodule

bind snd_interval_timers snd_interval_timers_chk #(.NUM_TMR(NUM_TMR), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .cnt_rd(cnt_rd),
   .cnt_wr(cnt_wr), .cnt_val(cnt_val));

// File: tb/tb_snd_interval_timers.sv
module tb_snd_interval_timers;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_tick = 1'b1;
   logic [2:0]  tmr_en = '0;
   logic [2:0]  per_wr = '0;
   logic [7:0]  per_data = '0;
   logic [2:0]  cnt_rd = '0;
   logic [2:0]  cnt_wr = '0;
   logic [11:0] cnt_val;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   snd_interval_timers dut (
      .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .tmr_en(tmr_en),
      .per_wr(per_wr), .per_data(per_data), .cnt_rd(cnt_rd),
      .cnt_wr(cnt_wr), .cnt_val(cnt_val));

   function automatic int cnt(input int i);
      return int'(cnt_val[i*4 +: 4]);
   endfunction

   task automatic adv(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic set_period(input int i, input int p);
      per_data  = 8'(p);
      per_wr[i] = 1'b1;
      adv(1);
      per_wr[i] = 1'b0;
   endtask

   // drop then raise enables in mask; returns just after edge E (m = 0)
   task automatic restart(input logic [2:0] mask);
      tmr_en = tmr_en & ~mask;
      adv(1);
      tmr_en = tmr_en | mask;
      adv(1);
   endtask

   task automatic t_reset;
      for (int i = 0; i < 3; i++) chk("R1 reset count", cnt(i), 0);
   endtask

   task automatic t_fast_period;
      set_period(2, 3);
      restart(3'b100);
      adv(47); chk("R2 R3 fast m=47", cnt(2), 0);
      adv(1);  chk("R2 R3 fast m=48", cnt(2), 1);
      adv(48); chk("R3 fast m=96", cnt(2), 2);
   endtask

   task automatic t_slow_period;
      set_period(0, 2);
      set_period(1, 2);
      restart(3'b011);
      adv(255); chk("R2 slow t0 m=255", cnt(0), 0);
                chk("R2 slow t1 m=255", cnt(1), 0);
      adv(1);   chk("R2 slow t0 m=256", cnt(0), 1);
                chk("R2 slow t1 m=256", cnt(1), 1);
      tmr_en[1:0] = 2'b00;
   endtask

   task automatic t_wrap;
      set_period(2, 1);
      restart(3'b100);
      adv(240); chk("R4 count 15", cnt(2), 15);
      adv(16);  chk("R4 wrap to 0", cnt(2), 0);
      adv(16);  chk("R4 after wrap", cnt(2), 1);
   endtask

   task automatic t_zero_period;
      set_period(2, 0);
      restart(3'b100);
      adv(4095); chk("R5 period0 m=4095", cnt(2), 0);
      adv(1);    chk("R5 period0 m=4096", cnt(2), 1);
   endtask

   task automatic t_clears;
      set_period(2, 1);
      restart(3'b100);
      adv(20);  chk("R6 read value", cnt(2), 1);
      cnt_rd[2] = 1'b1;
      adv(1);   cnt_rd[2] = 1'b0;
      chk("R6 cleared by read", cnt(2), 0);
      adv(10);  // m = 31, increment due at m = 32
      cnt_rd[2] = 1'b1;
      adv(1);   cnt_rd[2] = 1'b0;
      chk("R10 clear beats increment", cnt(2), 0);
      adv(16);  chk("R10 next increment", cnt(2), 1);
      adv(16);  chk("R7 before write", cnt(2), 2);
      per_data = 8'hA5;
      cnt_wr[2] = 1'b1;
      adv(1);   cnt_wr[2] = 1'b0;
      chk("R7 cleared by write", cnt(2), 0);
   endtask

   task automatic t_disable;
      set_period(2, 1);
      restart(3'b100);
      adv(40); chk("R8 before disable", cnt(2), 2);
      tmr_en[2] = 1'b0;
      adv(50); chk("R8 held while off", cnt(2), 2);
      tmr_en[2] = 1'b1;
      adv(1);  chk("R9 enable clears", cnt(2), 0);
      adv(15); chk("R9 phase restart m=15", cnt(2), 0);
      adv(1);  chk("R9 phase restart m=16", cnt(2), 1);
   endtask

   task automatic t_period_write;
      set_period(2, 4);
      restart(3'b100);
      adv(20);
      set_period(2, 4);  // m = 21
      adv(42); chk("R11 same value m=63", cnt(2), 0);
      adv(1);  chk("R11 same value m=64", cnt(2), 1);
      adv(10);
      set_period(2, 2);  // m = 75
      adv(20); chk("R11 new value m=95", cnt(2), 1);
      adv(1);  chk("R11 new value m=96", cnt(2), 2);
   endtask

   task automatic t_base_gate;
      set_period(2, 1);
      base_tick = 1'b0;
      restart(3'b100);
      adv(100); chk("R2 no base tick", cnt(2), 0);
      base_tick = 1'b1;
      adv(16);  chk("R2 base tick resumes", cnt(2), 1);
   endtask

   initial begin
      adv(4);
      rst_n = 1'b1;
      adv(1);
      t_reset();
      t_fast_period();
      t_slow_period();
      t_wrap();
      t_zero_period();
      t_clears();
      t_disable();
      t_period_write();
      t_base_gate();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule